// File: doc/BRIEF.md
# Vblank-Deferred Scanout Base Selector

This block picks the framebuffer base address that a display pipe scans out from. Software can program two base-address slots, each written as a low word and a high word, through a small register port. A control word carries a flip request bit, an output-enable bit and an active-low soft-reset bit, and it shows in a read-only bit which slot is live.

A flip request is not acted on at once. It is held pending until the next rising edge of the vertical blanking input. On that edge the live slot changes and the scanout address output is reloaded from the newly live slot. The scanout address output changes on vblank edges only. Software can therefore rewrite either slot at any moment, and a frame never starts from an address that was only partly updated. A later request switches back to the first slot.

Top module: `fb_flip_sel`

## Requirements
- R1: After reset, slot 0 is live, no flip is pending, output enable is 0, all base words and `scan_base_o` are 0, and the control word reads 0x0010_0000.
- R2: Register indices 1, 2, 3 and 4 hold slot 0 low, slot 0 high, slot 1 low and slot 1 high. Each reads back the last value written to it at any time. Indices 5 to 7 read 0 and writes to them change nothing.
- R3: In the control word (index 0), writing 1 to bit 7 makes a flip pending, and bit 7 reads 1 while it is pending. Writing 0 to bit 7 does not cancel a pending flip. Bit 11 is read-only and reads the live slot.
- R4: On a rising edge of `vblank_i` with a flip pending, the live slot toggles and the pending flag clears. In the following cycle, `scan_base_o` equals {high, low} of the newly live slot. A second flip returns to the first slot.
- R5: `scan_base_o` changes only on a rising edge of `vblank_i`. On such an edge with no flip pending, it reloads from the live slot. Holding `vblank_i` high for several cycles triggers one load only.
- R6: A flip write in the same cycle as a vblank edge is not served by that edge: it stays pending for the next edge, while an already-pending flip is still served. A base write in the same cycle as a vblank edge is not seen by that load: `scan_base_o` takes the contents from before the write.
- R7: Control bit 8 is stored as written and drives `out_en_o`.
- R8: A control write that takes bit 20 from 1 to 0 raises `pipe_rst_o` for exactly one cycle. It makes slot 0 live and clears any pending flip, including a flip requested in that same write. Base words are kept. Writing 0 to bit 20 while it is already 0 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register index for read and write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data of the indexed register, combinational |
| vblank_i | input | 1 | Vertical blanking level; its rising edge is the swap point |
| scan_base_o | output | 2*DATA_W | Base address used by scanout, {high, low} |
| scan_sel_o | output | 1 | Live slot |
| out_en_o | output | 1 | Output enable from control bit 8 |
| pipe_rst_o | output | 1 | One-cycle pipe reset pulse |

## Verification
Two events can land in the same cycle: a register write and the rising vblank edge that performs a swap. The write can be a flip request, a write to the live slot or a write to the idle slot. The bench sweeps all of these write kinds, with and without a flip already pending, both with the edge in the same cycle and with no edge. It then raises vblank again to expose what was left pending. The live slot, the pending bit and the loaded address are checked against a model that applies the rules above: a flip write does not count at the edge it coincides with, and a load sees the contents from before the write.

// File: rtl/fb_flip_pkg.sv
`timescale 1ns/1ps
package fb_flip_pkg;
  localparam int IDX_W          = 3;
  localparam int NUM_SLOT       = 2;
  localparam int CTRL_FLIP_BIT  = 7;
  localparam int CTRL_OEN_BIT   = 8;
  localparam int CTRL_SEL_BIT   = 11;
  localparam int CTRL_SRSTN_BIT = 20;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL  = 3'd0,
    IDX_S0_LO = 3'd1,
    IDX_S0_HI = 3'd2,
    IDX_S1_LO = 3'd3,
    IDX_S1_HI = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/fb_vblank_edge.sv
`timescale 1ns/1ps
module fb_vblank_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vblank_i,
  output logic rise_o
);
  logic vb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vb_q <= 1'b0;
    else         vb_q <= vblank_i;
  end

  assign rise_o = vblank_i & ~vb_q;
endmodule

// File: rtl/fb_base_bank.sv
`timescale 1ns/1ps
module fb_base_bank
  import fb_flip_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 we_i,
  input  logic [IDX_W-1:0]                     idx_i,
  input  logic [DATA_W-1:0]                    wdata_i,
  output logic [NUM_SLOT-1:0][2*DATA_W-1:0]    base_o
);
  // word index = 1 + 2*slot + half, half 0 = low word
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(1 + 2 * s + h);
      logic [DATA_W-1:0] word_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       word_q <= '0;
        else if (we_i && idx_i == MY_IDX)  word_q <= wdata_i;
      end

      assign base_o[s][h*DATA_W +: DATA_W] = word_q;
    end
  end
endmodule

// File: rtl/fb_flip_ctrl.sv
`timescale 1ns/1ps
module fb_flip_ctrl
  import fb_flip_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              vb_rise_i,
  output logic              sel_o,
  output logic              load_sel_o,
  output logic              pend_o,
  output logic              oen_o,
  output logic              srstn_o,
  output logic              pipe_rst_o
);
  logic sel_q, pend_q, oen_q, srstn_q, prst_q;
  logic ctrl_wr, srst_evt, flip_wr, swap_sel;

  assign ctrl_wr  = we_i && (idx_i == IDX_CTRL);
  assign srst_evt = ctrl_wr && srstn_q && !wdata_i[CTRL_SRSTN_BIT];
  assign flip_wr  = ctrl_wr && wdata_i[CTRL_FLIP_BIT] && !srst_evt;
  // slot the vblank load uses: a pending flip is served by this edge
  assign swap_sel = sel_q ^ (vb_rise_i & pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      pend_q  <= 1'b0;
      oen_q   <= 1'b0;
      srstn_q <= 1'b1;
      prst_q  <= 1'b0;
    end else begin
      prst_q <= srst_evt;
      if (ctrl_wr) begin
        oen_q   <= wdata_i[CTRL_OEN_BIT];
        srstn_q <= wdata_i[CTRL_SRSTN_BIT];
      end
      if (srst_evt) begin
        sel_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        sel_q <= swap_sel;
        if (flip_wr)        pend_q <= 1'b1;
        else if (vb_rise_i) pend_q <= 1'b0;
      end
    end
  end

  assign sel_o      = sel_q;
  assign load_sel_o = swap_sel;
  assign pend_o     = pend_q;
  assign oen_o      = oen_q;
  assign srstn_o    = srstn_q;
  assign pipe_rst_o = prst_q;
endmodule

// File: rtl/fb_scan_latch.sv
`timescale 1ns/1ps
module fb_scan_latch
  import fb_flip_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              load_i,
  input  logic                              sel_i,
  input  logic [NUM_SLOT-1:0][2*DATA_W-1:0] base_i,
  output logic [2*DATA_W-1:0]               scan_base_o
);
  logic [2*DATA_W-1:0] scan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     scan_q <= '0;
    else if (load_i) scan_q <= base_i[sel_i];
  end

  assign scan_base_o = scan_q;
endmodule

// File: rtl/fb_flip_sel.sv
`timescale 1ns/1ps
module fb_flip_sel
  import fb_flip_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [IDX_W-1:0]      reg_idx_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic                  vblank_i,
  output logic [2*DATA_W-1:0]   scan_base_o,
  output logic                  scan_sel_o,
  output logic                  out_en_o,
  output logic                  pipe_rst_o
);
  logic                              vb_rise;
  logic                              load_sel;
  logic                              flip_pend;
  logic                              srstn;
  logic [NUM_SLOT-1:0][2*DATA_W-1:0] base;
  logic [DATA_W-1:0]                 ctrl_rd;

  fb_vblank_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vblank_i (vblank_i),
    .rise_o   (vb_rise)
  );

  fb_base_bank #(.DATA_W(DATA_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .idx_i   (reg_idx_i),
    .wdata_i (reg_wdata_i),
    .base_o  (base)
  );

  fb_flip_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .idx_i      (reg_idx_i),
    .wdata_i    (reg_wdata_i),
    .vb_rise_i  (vb_rise),
    .sel_o      (scan_sel_o),
    .load_sel_o (load_sel),
    .pend_o     (flip_pend),
    .oen_o      (out_en_o),
    .srstn_o    (srstn),
    .pipe_rst_o (pipe_rst_o)
  );

  fb_scan_latch #(.DATA_W(DATA_W)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (vb_rise),
    .sel_i       (load_sel),
    .base_i      (base),
    .scan_base_o (scan_base_o)
  );

  always_comb begin
    ctrl_rd                 = '0;
    ctrl_rd[CTRL_FLIP_BIT]  = flip_pend;
    ctrl_rd[CTRL_OEN_BIT]   = out_en_o;
    ctrl_rd[CTRL_SEL_BIT]   = scan_sel_o;
    ctrl_rd[CTRL_SRSTN_BIT] = srstn;
  end

  always_comb begin
    case (reg_idx_i)
      IDX_CTRL:  reg_rdata_o = ctrl_rd;
      IDX_S0_LO: reg_rdata_o = base[0][DATA_W-1:0];
      IDX_S0_HI: reg_rdata_o = base[0][2*DATA_W-1:DATA_W];
      IDX_S1_LO: reg_rdata_o = base[1][DATA_W-1:0];
      IDX_S1_HI: reg_rdata_o = base[1][2*DATA_W-1:DATA_W];
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fb_flip_sel_chk.sv
`timescale 1ns/1ps
module fb_flip_sel_chk
  import fb_flip_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_we_i,
  input logic [IDX_W-1:0]      reg_idx_i,
  input logic [DATA_W-1:0]     reg_wdata_i,
  input logic                  vblank_i,
  input logic [2*DATA_W-1:0]   scan_base_o,
  input logic                  scan_sel_o,
  input logic                  pipe_rst_o,
  input logic                  flip_pend
);
  logic vb_d;
  logic edge_seen;
  logic ctrl_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vb_d <= 1'b0;
    else         vb_d <= vblank_i;
  end

  assign edge_seen = vblank_i && !vb_d;
  assign ctrl_wr   = reg_we_i && (reg_idx_i == IDX_CTRL);

  AST_SCAN_ONLY_AT_VBLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scan_base_o) |-> $past(edge_seen)); // R5

  AST_SEL_ONLY_AT_VBLANK_OR_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scan_sel_o) |-> ($past(edge_seen) || pipe_rst_o)); // R4

  AST_PEND_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_pend && edge_seen && !ctrl_wr) |=> (!flip_pend && (scan_sel_o != $past(scan_sel_o)))); // R4

  AST_FLIP_REQ_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[CTRL_FLIP_BIT] && reg_wdata_i[CTRL_SRSTN_BIT]) |=> flip_pend); // R3

  AST_RST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_rst_o |=> !pipe_rst_o); // R8

  AST_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_rst_o |-> (!scan_sel_o && !flip_pend)); // R8
endmodule

bind fb_flip_sel fb_flip_sel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_idx_i   (reg_idx_i),
  .reg_wdata_i (reg_wdata_i),
  .vblank_i    (vblank_i),
  .scan_base_o (scan_base_o),
  .scan_sel_o  (scan_sel_o),
  .pipe_rst_o  (pipe_rst_o),
  .flip_pend   (flip_pend)
);

// File: tb/fb_flip_sel_test.sv
`timescale 1ns/1ps
module fb_flip_sel_test;
  localparam int DW = 32;
  localparam logic [DW-1:0] W_FLIP = 32'h0010_0180; // srstn=1, oen=1, flip=1
  localparam logic [DW-1:0] W_IDLE = 32'h0010_0100; // srstn=1, oen=1

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [2:0]    reg_idx_i = 3'd0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [DW-1:0] reg_rdata_o;
  logic          vblank_i = 1'b0;
  logic [2*DW-1:0] scan_base_o;
  logic          scan_sel_o, out_en_o, pipe_rst_o;

  fb_flip_sel #(.DATA_W(DW)) uut (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model
  bit          sel_m, pend_m, en_m, srb_m, prst_m, vbp_m;
  logic [DW-1:0] base_m [4];
  logic [2*DW-1:0] scan_m;

  task automatic cmp(input string req, input string what, input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ctrl_exp();
    logic [DW-1:0] v = '0;
    v[20] = srb_m; v[11] = sel_m; v[8] = en_m; v[7] = pend_m;
    return v;
  endfunction

  task automatic chk(input string req);
    reg_idx_i = 3'd0;
    #0.5;
    cmp(req, "scan_sel", 64'(scan_sel_o), 64'(sel_m));
    cmp(req, "scan_base", scan_base_o, scan_m);
    cmp("R7", "out_en", 64'(out_en_o), 64'(en_m));
    cmp("R8", "pipe_rst", 64'(pipe_rst_o), 64'(prst_m));
    cmp("R3", "ctrl_rd", 64'(reg_rdata_o), 64'(ctrl_exp()));
  endtask

  task automatic cyc(input bit we, input logic [2:0] idx, input logic [DW-1:0] wd, input bit vb, input string req);
    bit vbe, cw, revt, nsel;
    reg_we_i = we; reg_idx_i = idx; reg_wdata_i = wd; vblank_i = vb;
    @(posedge clk_i);
    vbe  = vb && !vbp_m;
    vbp_m = vb;
    cw   = we && idx == 3'd0;
    revt = cw && srb_m && !wd[20];
    nsel = (vbe && pend_m) ? ~sel_m : sel_m;
    if (vbe) scan_m = nsel ? {base_m[3], base_m[2]} : {base_m[1], base_m[0]};
    prst_m = revt;
    if (revt) begin
      sel_m = 1'b0; pend_m = 1'b0;
    end else begin
      sel_m = nsel;
      if (cw && wd[7]) pend_m = 1'b1;
      else if (vbe)    pend_m = 1'b0;
    end
    if (cw) begin en_m = wd[8]; srb_m = wd[20]; end
    if (we && idx >= 3'd1 && idx <= 3'd4) base_m[idx-3'd1] = wd;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    chk(req);
  endtask

  task automatic rd_all(input string req);
    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] e;
      @(negedge clk_i);
      reg_idx_i = 3'(i);
      #1;
      if (i == 0)      e = ctrl_exp();
      else if (i <= 4) e = base_m[i-1];
      else             e = '0;
      cmp(req, $sformatf("rd idx%0d", i), 64'(reg_rdata_o), 64'(e));
    end
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    sel_m = 0; pend_m = 0; en_m = 0; srb_m = 1; prst_m = 0; vbp_m = 0; scan_m = '0;
    for (int i = 0; i < 4; i++) base_m[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1");
    rd_all("R1");

    // load both slots, R2
    for (int i = 1; i <= 4; i++)
      cyc(1'b1, 3'(i), 32'h1000_0000 * i + 32'h0000_0abc * i, 1'b0, "R2");
    rd_all("R2");
    // unmapped indices: writes ignored, read 0, R2
    for (int i = 5; i < 8; i++) cyc(1'b1, 3'(i), 32'hdead_0000 + i, 1'b0, "R2");
    rd_all("R2");

    // first vblank with nothing pending: load from slot 0, R5
    cyc(1'b0, 3'd0, '0, 1'b1, "R5");
    cyc(1'b0, 3'd0, '0, 1'b0, "R5");

    // flip, then write 0 to flip bit (no cancel), then swap and swap back, R3 R4
    cyc(1'b1, 3'd0, W_FLIP, 1'b0, "R3");
    cyc(1'b1, 3'd0, W_IDLE, 1'b0, "R3");
    cyc(1'b0, 3'd0, '0, 1'b1, "R4");
    cyc(1'b0, 3'd0, '0, 1'b0, "R4");
    cyc(1'b1, 3'd0, W_FLIP, 1'b0, "R4");
    cyc(1'b0, 3'd0, '0, 1'b1, "R4");
    cyc(1'b0, 3'd0, '0, 1'b0, "R4");

    // held-high vblank: a flip requested mid-high waits for the next rise, R5
    cyc(1'b0, 3'd0, '0, 1'b1, "R5");
    cyc(1'b1, 3'd0, W_FLIP, 1'b1, "R5");
    cyc(1'b1, 3'd1, 32'h5555_0001, 1'b1, "R5");
    cyc(1'b0, 3'd0, '0, 1'b1, "R5");
    cyc(1'b0, 3'd0, '0, 1'b0, "R5");
    cyc(1'b0, 3'd0, '0, 1'b1, "R4");
    cyc(1'b0, 3'd0, '0, 1'b0, "R4");

    // coincidence sweep: write kind x vblank edge x pending before, R6
    for (int p = 0; p < 16; p++) begin
      logic [1:0] op = 2'(p);
      bit vbr = p[2];
      bit pre = p[3];
      logic [DW-1:0] d = 32'ha000_0000 + 32'h0000_0111 * p;
      cyc(1'b0, 3'd0, '0, 1'b0, "R6");
      if (pre) cyc(1'b1, 3'd0, W_FLIP, 1'b0, "R6");
      case (op)
        2'd0: cyc(1'b0, 3'd0, '0, vbr, "R6");
        2'd1: cyc(1'b1, 3'd0, W_FLIP, vbr, "R6");
        2'd2: cyc(1'b1, sel_m ? 3'd3 : 3'd1, d, vbr, "R6");
        default: cyc(1'b1, sel_m ? 3'd2 : 3'd4, d ^ 32'hffff_0000, vbr, "R6");
      endcase
      cyc(1'b0, 3'd0, '0, 1'b0, "R6");
      cyc(1'b0, 3'd0, '0, 1'b1, "R6");
      cyc(1'b0, 3'd0, '0, 1'b1, "R5");
      cyc(1'b0, 3'd0, '0, 1'b0, "R5");
    end
    rd_all("R2");

    // output enable off then on, R7
    cyc(1'b1, 3'd0, 32'h0010_0000, 1'b0, "R7");
    cyc(1'b1, 3'd0, W_IDLE, 1'b0, "R7");

    // soft reset: get slot 1 live and a flip pending, then 1->0 with flip bit, R8
    if (!sel_m) begin
      cyc(1'b1, 3'd0, W_FLIP, 1'b0, "R8");
      cyc(1'b0, 3'd0, '0, 1'b1, "R8");
      cyc(1'b0, 3'd0, '0, 1'b0, "R8");
    end
    cyc(1'b1, 3'd0, W_FLIP, 1'b0, "R8");
    cmp("R8", "pre sel", 64'(scan_sel_o), 64'd1);
    cyc(1'b1, 3'd0, 32'h0000_0180, 1'b0, "R8");
    cmp("R8", "pulse", 64'(pipe_rst_o), 64'd1);
    cyc(1'b0, 3'd0, '0, 1'b0, "R8");
    cyc(1'b1, 3'd0, 32'h0000_0000, 1'b0, "R8");
    cyc(1'b1, 3'd0, W_IDLE, 1'b0, "R8");
    rd_all("R8");
    cyc(1'b0, 3'd0, '0, 1'b1, "R8");
    cyc(1'b0, 3'd0, '0, 1'b0, "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule